// File: doc/BRIEF.md
# Vector Issue Scoreboard with Region-Aware Forwarding Latency

This block sits in front of a single-issue vector pipeline and decides, cycle by cycle, whether the instruction on offer may issue. For every architectural vector register it records which class of operation last wrote it and how many cycles remain before that result can be forwarded. Only two consumer classes exist: a vector ALU add and a dot-product multiply-accumulate.

Operand readiness is not one latency per producer. An ALU consumer that reads a result from the multiply-accumulate unit pays one extra cycle, because the ALU forwarding region does not include that unit. A dot product that takes its accumulator operand from another dot product takes it late in its own pipeline, so chained accumulation can issue every cycle. When the instruction issues, its destination entry is reloaded with the producer class and the countdown for the new result.

Each instruction carries a class bit, a destination index and three source indexes. The third source slot is the accumulator slot. A three-bit enable mask says which slots are real operands. The block asserts `issue_ok` only when the instruction is valid and every enabled operand is ready.

Top module: `vsb_scoreboard`

## Requirements
- R1: After reset every register reads as ready, so any instruction that reads any register issues in the cycle it is presented.
- R2: `issue_ok` is low whenever `inst_valid` is low. A source slot whose bit in `inst_src_en` is 0 (bit 0 = slot a, bit 1 = slot b, bit 2 = accumulator slot) never delays issue, whatever register it names.
- R3: An ALU result (`inst_mac`=0) can be used by an ALU consumer 2 cycles after the producer issues, which is one stall cycle for a back-to-back dependency.
- R4: A dot-product result (`inst_mac`=1) read through slot a or slot b of another dot product can be used 3 cycles after the producer issues, which is two stall cycles.
- R5: A dot-product result read through the accumulator slot of another dot product can be used on the next cycle, with no stall.
- R6: An ALU consumer reading a dot-product result through any slot waits one extra cycle for the region crossing: 4 cycles, or three stall cycles.
- R7: A dot-product consumer reading an ALU result, through any slot including the accumulator slot, sees the ALU's 2-cycle latency: one stall cycle.
- R8: A chain of dot product, then add, then a dot product accumulating the add's result repeats every 6 cycles (3 stalls before the add, 1 before the dot product).
- R9: An instruction that does not issue, because it is stalled or not valid, leaves the tracking of its destination register unchanged.
- R10: Countdowns stop at zero. A register whose producer finished long ago is ready for any consumer in any slot.
- R11: Issuing to a register replaces its tracking, so the latest issued writer's class and latency govern later readers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | An instruction is offered this cycle |
| inst_mac | input | 1 | 1 = dot-product multiply-accumulate, 0 = vector ALU add |
| inst_dst | input | $clog2(NREG) | Destination register index |
| inst_src_a | input | $clog2(NREG) | Source slot a register index |
| inst_src_b | input | $clog2(NREG) | Source slot b register index |
| inst_src_acc | input | $clog2(NREG) | Accumulator slot register index |
| inst_src_en | input | 3 | Slot enables: bit 0 a, bit 1 b, bit 2 accumulator |
| issue_ok | output | 1 | The offered instruction issues at this clock edge |

## Verification
A wrong countdown value or a wrong class code in an entry does not show up until some later instruction reads that register. It then appears at `issue_ok` as a grant one or more cycles too early or too late, within at most four cycles of the producer issuing. The bench therefore issues a producer, holds a dependent consumer on the inputs, and counts the exact stall cycles for every pairing of producer class, consumer class and slot. A destination that is wrongly loaded by an instruction that was stalled or not valid shows up as a stall on an immediate reader that should see none.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
    // Producer class recorded per register
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_ALU  = 2'd1,
        CLS_MAC  = 2'd2
    } prod_cls_e;
endpackage

// File: rtl/vsb_entry.sv
module vsb_entry
    import vsb_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  prod_cls_e     load_cls,
    output logic [CW-1:0] rem,
    output prod_cls_e     cls
);
    typedef struct packed {
        logic [CW-1:0] rem;
        prod_cls_e     cls;
    } ent_t;

    ent_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.rem = load_val;
            st_d.cls = load_cls;
        end else if (st_q.rem != '0) begin
            st_d.rem = st_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rem = st_q.rem;
    assign cls = st_q.cls;

    // R11: an issue replaces the entry with the new writer's state
    assert_load_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rem == $past(load_val)) && (cls == $past(load_cls)));

    // R10: countdown drops by one per cycle when not reloaded
    assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rem != '0) |=> rem == $past(rem) - 1'b1);

    // R10: countdown stays at zero when not reloaded
    assert_hold_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rem == '0) |=> rem == '0);
endmodule

// File: rtl/vsb_operand_check.sv
module vsb_operand_check
    import vsb_pkg::*;
#(
    parameter int CW       = 3,
    parameter int THR_SAME = 2,
    parameter int THR_XREG = 1,
    parameter int THR_ACC  = 4
) (
    input  logic          en,
    input  logic          is_acc,
    input  logic          cons_mac,
    input  prod_cls_e     prod_cls,
    input  logic [CW-1:0] prod_rem,
    output logic          ready
);
    logic [CW:0] thr;

    always_comb begin
        if (prod_cls == CLS_MAC && cons_mac && is_acc)
            thr = (CW+1)'(THR_ACC);        // late accumulator forward
        else if (prod_cls == CLS_MAC && !cons_mac)
            thr = (CW+1)'(THR_XREG);       // leaving the multiply unit into the ALU region
        else
            thr = (CW+1)'(THR_SAME);
        ready = !en || ({1'b0, prod_rem} <= thr);
    end
endmodule

// File: rtl/vsb_scoreboard.sv
module vsb_scoreboard
    import vsb_pkg::*;
#(
    parameter int NREG    = 8,
    parameter int LAT_ALU = 2,
    parameter int LAT_MAC = 3,
    parameter int LAT_ACC = 1,
    parameter int XPEN    = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inst_valid,
    input  logic                    inst_mac,
    input  logic [$clog2(NREG)-1:0] inst_dst,
    input  logic [$clog2(NREG)-1:0] inst_src_a,
    input  logic [$clog2(NREG)-1:0] inst_src_b,
    input  logic [$clog2(NREG)-1:0] inst_src_acc,
    input  logic [2:0]              inst_src_en,
    output logic                    issue_ok
);
    localparam int IW      = $clog2(NREG);
    localparam int MAXLAT  = ((LAT_ALU > LAT_MAC) ? LAT_ALU : LAT_MAC) + XPEN;
    localparam int CW      = $clog2(MAXLAT + 1);
    // A countdown loaded with L+XPEN reaches value r after (L+XPEN+1-r) cycles.
    localparam int THR_SAME = XPEN + 1;
    localparam int THR_XREG = 1;
    localparam int THR_ACC  = LAT_MAC + XPEN + 1 - LAT_ACC;
    localparam logic [CW-1:0] LOAD_ALU = CW'(LAT_ALU + XPEN);
    localparam logic [CW-1:0] LOAD_MAC = CW'(LAT_MAC + XPEN);

    logic [CW-1:0] rem_all [NREG];
    prod_cls_e     cls_all [NREG];
    logic [IW-1:0] src_idx [3];
    logic [2:0]    src_rdy;
    logic [CW-1:0] load_val;
    prod_cls_e     load_cls;

    always_comb begin
        src_idx[0] = inst_src_a;
        src_idx[1] = inst_src_b;
        src_idx[2] = inst_src_acc;
        load_val   = inst_mac ? LOAD_MAC : LOAD_ALU;
        load_cls   = inst_mac ? CLS_MAC : CLS_ALU;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        vsb_entry #(.CW(CW)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (issue_ok && (inst_dst == IW'(g))),
            .load_val (load_val),
            .load_cls (load_cls),
            .rem      (rem_all[g]),
            .cls      (cls_all[g])
        );
    end

    for (genvar s = 0; s < 3; s++) begin : g_src
        vsb_operand_check #(
            .CW(CW), .THR_SAME(THR_SAME), .THR_XREG(THR_XREG), .THR_ACC(THR_ACC)
        ) u_chk (
            .en       (inst_src_en[s]),
            .is_acc   (s == 2),
            .cons_mac (inst_mac),
            .prod_cls (cls_all[src_idx[s]]),
            .prod_rem (rem_all[src_idx[s]]),
            .ready    (src_rdy[s])
        );
    end

    assign issue_ok = inst_valid && (&src_rdy);

    // R2: no grant without a valid instruction
    assert_valid_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> inst_valid);

    // R6: an ALU consumer of a multiply result in slot a issues only at the last countdown step
    assert_xreg_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && inst_src_en[0] && !inst_mac && cls_all[inst_src_a] == CLS_MAC)
            |-> rem_all[inst_src_a] <= CW'(1));

    // R5: a dot product never waits on a dot-product accumulator that is one cycle old
    assert_acc_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid && inst_mac && inst_src_en == 3'b100 && cls_all[inst_src_acc] == CLS_MAC)
            |-> issue_ok);
endmodule

// File: tb/sim_vsb_scoreboard.sv
`timescale 1ns/100ps
module sim_vsb_scoreboard;
    localparam int NREG = 8;
    localparam int IW = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inst_valid = 1'b0;
    logic          inst_mac = 1'b0;
    logic [IW-1:0] inst_dst = '0;
    logic [IW-1:0] inst_src_a = '0;
    logic [IW-1:0] inst_src_b = '0;
    logic [IW-1:0] inst_src_acc = '0;
    logic [2:0]    inst_src_en = '0;
    logic          issue_ok;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vsb_scoreboard #(.NREG(NREG)) u0 (
        .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_mac(inst_mac),
        .inst_dst(inst_dst), .inst_src_a(inst_src_a), .inst_src_b(inst_src_b),
        .inst_src_acc(inst_src_acc), .inst_src_en(inst_src_en), .issue_ok(issue_ok)
    );

    // Vector fields: [11:8] requirement number, [7] producer is dot product,
    // [6] consumer is dot product, [5:4] consumer slot (0 a, 1 b, 2 acc), [3:0] stall cycles
    localparam logic [11:0] VEC [9] = '{
        {4'd3, 1'b0, 1'b0, 2'd0, 4'd1},   // R3 add -> add, slot a
        {4'd3, 1'b0, 1'b0, 2'd1, 4'd1},   // R3 add -> add, slot b
        {4'd4, 1'b1, 1'b1, 2'd0, 4'd2},   // R4 dot -> dot data, slot a
        {4'd4, 1'b1, 1'b1, 2'd1, 4'd2},   // R4 dot -> dot data, slot b
        {4'd5, 1'b1, 1'b1, 2'd2, 4'd0},   // R5 dot -> dot accumulator
        {4'd6, 1'b1, 1'b0, 2'd0, 4'd3},   // R6 dot -> add, slot a
        {4'd6, 1'b1, 1'b0, 2'd2, 4'd3},   // R6 dot -> add, third slot
        {4'd7, 1'b0, 1'b1, 2'd0, 4'd1},   // R7 add -> dot, slot a
        {4'd7, 1'b0, 1'b1, 2'd2, 4'd1}    // R7 add -> dot accumulator
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        inst_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Present an instruction from the next falling edge and count stall cycles until granted
    task automatic offer(input bit mac, input int dst, input int a, input int b,
                         input int acc, input logic [2:0] en, output int stall);
        @(negedge clk);
        inst_valid   = 1'b1;
        inst_mac     = mac;
        inst_dst     = IW'(dst);
        inst_src_a   = IW'(a);
        inst_src_b   = IW'(b);
        inst_src_acc = IW'(acc);
        inst_src_en  = en;
        stall = 0;
        #1;
        while (!issue_ok && stall < 20) begin
            stall++;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int st, st2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register ready after reset
        for (int r = 0; r < NREG; r++) begin
            offer(1'b0, r, r, r, r, 3'b111, st);
            chk(st == 0, "R1 reset ready", st, 0);
        end
        idle(8);

        // R2: no grant without valid
        @(negedge clk);
        inst_valid = 1'b0; inst_src_en = 3'b000;
        #1;
        chk(issue_ok == 1'b0, "R2 valid low", int'(issue_ok), 0);

        // R2: disabled slots naming a busy register do not stall
        offer(1'b1, 5, 0, 0, 0, 3'b000, st);
        offer(1'b0, 6, 5, 5, 5, 3'b000, st);
        chk(st == 0, "R2 disabled slots", st, 0);
        idle(8);

        // R3..R7: table of producer/consumer pairings
        for (int i = 0; i < 9; i++) begin
            logic [11:0] v;
            logic [2:0] en;
            string tag;
            v = VEC[i];
            en = 3'b001 << v[5:4];
            tag = $sformatf("R%0d vector %0d", v[11:8], i);
            offer(v[7], 1, 0, 0, 0, 3'b000, st);
            chk(st == 0, tag, st, 0);
            offer(v[6], 2, 1, 1, 1, en, st);
            chk(st == int'(v[3:0]), tag, st, int'(v[3:0]));
            idle(8);
        end

        // R8: dot -> add -> dot accumulator loop period
        offer(1'b1, 1, 0, 0, 0, 3'b000, st);
        offer(1'b0, 2, 1, 1, 0, 3'b011, st);
        chk(st == 3, "R8 stall before add", st, 3);
        offer(1'b1, 1, 3, 4, 2, 3'b111, st2);
        chk(st2 == 1, "R8 stall before dot", st2, 1);
        chk(st + st2 + 2 == 6, "R8 loop period", st + st2 + 2, 6);
        idle(8);

        // R9: a stalled instruction does not load its destination
        offer(1'b1, 3, 0, 0, 0, 3'b000, st);
        @(negedge clk);
        inst_valid = 1'b1; inst_mac = 1'b0; inst_dst = IW'(4);
        inst_src_a = IW'(3); inst_src_en = 3'b001;
        #1;
        chk(issue_ok == 1'b0, "R9 stalled", int'(issue_ok), 0);
        offer(1'b0, 6, 4, 4, 4, 3'b111, st);
        chk(st == 0, "R9 stalled dst untouched", st, 0);
        // R9: an invalid instruction does not load its destination
        @(negedge clk);
        inst_valid = 1'b0; inst_mac = 1'b1; inst_dst = IW'(7); inst_src_en = 3'b000;
        offer(1'b0, 0, 7, 7, 7, 3'b111, st);
        chk(st == 0, "R9 invalid dst untouched", st, 0);
        idle(8);

        // R10: long-finished producer ready for a crossing consumer
        offer(1'b1, 3, 0, 0, 0, 3'b000, st);
        idle(15);
        offer(1'b0, 4, 3, 3, 3, 3'b111, st);
        chk(st == 0, "R10 saturated ready", st, 0);
        idle(8);

        // R11: latest writer replaces tracking
        offer(1'b1, 1, 0, 0, 0, 3'b000, st);
        offer(1'b0, 1, 0, 0, 0, 3'b000, st);
        chk(st == 0, "R11 overwrite issue", st, 0);
        offer(1'b0, 2, 1, 0, 0, 3'b001, st);
        chk(st == 1, "R11 latest writer governs", st, 1);
        idle(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule